// File: doc/BRIEF.md
# Five-Stage Pipeline Advance and Flush Controller

This block moves instruction tokens through a five-stage in-order pipeline: fetch, decode, operand fetch, execute and writeback. Each stage holds a valid bit and a tag. The block decides on every cycle which stages load new contents, which are cleared, and which address fetch asks for next. It decodes nothing and does no arithmetic, and tags travel through the stages unchanged.

Incoming instructions arrive on a valid/ready stream. A token is taken into the fetch stage only on a cycle where both `in_valid_i` and `in_ready_o` are high. While `in_ready_o` is low the source must hold its token and its tag. `in_ready_o` drops for two reasons. One is an operand-fetch stage that is busy with a memory access, which freezes that stage and every earlier one. The other is a taken branch that resolves in execute. Such a branch kills the three younger tokens and reloads the fetch address with the branch target. A branch that is not taken, or that resolves while execute is empty, changes nothing.

Top module: `pipe5_ctrl`

## Requirements
- R1: A token accepted in cycle n is in decode after edge n+1, operand fetch after n+2, execute after n+3 and writeback after n+4 if nothing stalls or kills it. Its tag is unchanged at every stage. `retire_o` equals the writeback valid bit, and `retire_tag_o` gives its tag.
- R2: With `in_valid_i` held high and no busy or taken branch, once the pipe is full one token retires on every cycle.
- R3: `in_ready_o` is low when a stall or a redirect is active and high otherwise. A token is accepted only when `in_valid_i` and `in_ready_o` are both high.
- R4: When `of_busy_i` is high and operand fetch holds a valid token, with no redirect, fetch, decode and operand fetch hold their contents and `stage_adv_o[2:0]` is 0. Execute receives a bubble, and writeback takes the old execute token. `stage_adv_o` bit i is 1 when stage i loads or clears on that edge.
- R5: A resolved branch with `br_taken_i` low causes no kill, no redirect and no change in flow.
- R6: A taken branch resolved while execute is valid raises `kill_o[i]` for each valid stage among fetch (bit 0), decode (bit 1) and operand fetch (bit 2), and clears those three stages on the edge. The branch itself moves on to writeback, and `fetch_addr_o` becomes `br_target_i`.
- R7: When a redirect and an operand-fetch stall meet in the same cycle, the redirect wins. The stalled stages are cleared, and writeback still takes the branch.
- R8: `fetch_addr_o` grows by SLOT_BYTES on each accepted token and holds its value on every other cycle that has no redirect.
- R9: After reset every stage is invalid and `fetch_addr_o` equals `reset_vec_i`.
- R10: `br_resolve_i` has no effect while execute holds no valid token.
- R11: `of_busy_i` has no effect while operand fetch holds no valid token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_vec_i | input | ADDR_W | Fetch address loaded on reset |
| in_valid_i | input | 1 | Incoming token present |
| in_tag_i | input | TAG_W | Tag of the incoming token |
| in_ready_o | output | 1 | Fetch stage can take a token |
| of_busy_i | input | 1 | Operand fetch is still busy with memory |
| br_resolve_i | input | 1 | Execute resolves a branch this cycle |
| br_taken_i | input | 1 | The resolved branch is taken |
| br_target_i | input | ADDR_W | Target address of a taken branch |
| fetch_addr_o | output | ADDR_W | Address of the next fetch |
| stage_adv_o | output | 5 | Per-stage load enable (0 = hold) |
| kill_o | output | 3 | Per-stage kill for fetch, decode, operand fetch |
| stage_vld_o | output | 5 | Valid bit of each stage |
| retire_o | output | 1 | Writeback holds a valid token |
| retire_tag_o | output | TAG_W | Tag of the retiring token |

## Verification
The bench aims at a taken branch that lands in the same cycle as an operand-fetch stall. A design that lets the stall win there would leave wrong-path tokens alive and would never redirect. It runs long busy stretches and checks that execute gets bubbles while writeback drains. A design that froze the whole pipe would hold a token in execute, and one that failed to freeze would lose or duplicate upstream tags. It also drives branch resolves while execute is empty and busy pulses while operand fetch is empty. A design that ignored the valid qualifier would kill good tokens or drop `in_ready_o` for no reason. Random traffic is compared each cycle against a reference model, which catches a fetch address that steps on rejected offers.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int NSTG   = 5;
  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_OF  = 2;
  localparam int ST_EX  = 3;
  localparam int ST_WB  = 4;
  localparam int NKILL  = ST_OF + 1;
endpackage

// File: rtl/pipe5_hazard.sv
module pipe5_hazard
  import pipe5_pkg::*;
(
  input  logic [NSTG-1:0]  vld_i,
  input  logic             of_busy_i,
  input  logic             br_resolve_i,
  input  logic             br_taken_i,
  input  logic             in_valid_i,
  output logic             redirect_o,
  output logic             stall_o,
  output logic             in_ready_o,
  output logic             accept_o,
  output logic [NSTG-1:0]  adv_o,
  output logic [NKILL-1:0] kill_o
);
  // a redirect needs a real branch in execute; a stall needs a real token in operand fetch
  always_comb begin
    redirect_o = br_resolve_i & br_taken_i & vld_i[ST_EX];
    stall_o    = of_busy_i & vld_i[ST_OF] & ~redirect_o;
    in_ready_o = ~stall_o & ~redirect_o;
    accept_o   = in_valid_i & in_ready_o;
  end

  for (genvar i = 0; i < NSTG; i++) begin : g_adv
    if (i <= ST_OF) begin : g_up
      assign adv_o[i] = ~stall_o;
    end else begin : g_down
      assign adv_o[i] = 1'b1;
    end
  end

  for (genvar k = 0; k < NKILL; k++) begin : g_kill
    assign kill_o[k] = redirect_o & vld_i[k];
  end
endmodule

// File: rtl/pipe5_stage.sv
module pipe5_stage #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic             up_vld_i,
  input  logic [TAG_W-1:0] up_tag_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      tag_o <= '0;
    end else if (clear_i) begin
      vld_o <= 1'b0;
    end else if (load_i) begin
      vld_o <= up_vld_i;
      if (up_vld_i) tag_o <= up_tag_i;
    end
  end
endmodule

// File: rtl/pipe5_fetch_addr.sv
module pipe5_fetch_addr #(
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reset_vec_i,
  input  logic              accept_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SLOT_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n)          addr_o <= reset_vec_i;
    else if (redirect_i) addr_o <= target_i;
    else if (accept_i)   addr_o <= addr_o + STEP;
  end
endmodule

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reset_vec_i,
  input  logic              in_valid_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  output logic              in_ready_o,
  input  logic              of_busy_i,
  input  logic              br_resolve_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] br_target_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [NSTG-1:0]   stage_adv_o,
  output logic [NKILL-1:0]  kill_o,
  output logic [NSTG-1:0]   stage_vld_o,
  output logic              retire_o,
  output logic [TAG_W-1:0]  retire_tag_o
);
  logic             redirect, stall, accept;
  logic [NSTG-1:0]  vld;
  logic [TAG_W-1:0] tag [NSTG];
  logic [NSTG-1:0]  up_vld;
  logic [TAG_W-1:0] up_tag [NSTG];

  pipe5_hazard u_haz (
    .vld_i        (vld),
    .of_busy_i    (of_busy_i),
    .br_resolve_i (br_resolve_i),
    .br_taken_i   (br_taken_i),
    .in_valid_i   (in_valid_i),
    .redirect_o   (redirect),
    .stall_o      (stall),
    .in_ready_o   (in_ready_o),
    .accept_o     (accept),
    .adv_o        (stage_adv_o),
    .kill_o       (kill_o)
  );

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    if (i == ST_IF) begin : g_src
      assign up_vld[i] = accept;
      assign up_tag[i] = in_tag_i;
    end else if (i == ST_EX) begin : g_bub
      // execute takes a bubble while operand fetch is frozen or killed
      assign up_vld[i] = vld[i-1] & ~stall & ~redirect;
      assign up_tag[i] = tag[i-1];
    end else begin : g_mid
      assign up_vld[i] = vld[i-1];
      assign up_tag[i] = tag[i-1];
    end

    pipe5_stage #(.TAG_W(TAG_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (stage_adv_o[i]),
      .clear_i  ((i <= ST_OF) ? redirect : 1'b0),
      .up_vld_i (up_vld[i]),
      .up_tag_i (up_tag[i]),
      .vld_o    (vld[i]),
      .tag_o    (tag[i])
    );
  end

  pipe5_fetch_addr #(.ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES)) u_fa (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_vec_i (reset_vec_i),
    .accept_i    (accept),
    .redirect_i  (redirect),
    .target_i    (br_target_i),
    .addr_o      (fetch_addr_o)
  );

  assign stage_vld_o  = vld;
  assign retire_o     = vld[ST_WB];
  assign retire_tag_o = tag[ST_WB];
endmodule

// File: rtl/pipe5_ctrl_chk.sv
module pipe5_ctrl_chk
  import pipe5_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              of_busy_i,
  input logic              br_resolve_i,
  input logic              br_taken_i,
  input logic [ADDR_W-1:0] br_target_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [NKILL-1:0]  kill_o,
  input logic [NSTG-1:0]   stage_vld_o,
  input logic              retire_o
);
  logic redir_seen;
  assign redir_seen = br_resolve_i & br_taken_i & stage_vld_o[ST_EX];

  // R1
  ex_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_vld_o[ST_EX] |=> retire_o);

  // R3
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (of_busy_i && stage_vld_o[ST_OF]) |-> !in_ready_o);

  // R4
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (of_busy_i && stage_vld_o[ST_OF] && !redir_seen) |=> !stage_vld_o[ST_EX]);

  // R6
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_seen |=> (stage_vld_o[ST_OF:ST_IF] == '0) && (fetch_addr_o == $past(br_target_i)));

  // R6
  kill_only_on_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_seen |-> (kill_o == '0));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid_i && in_ready_o) && !redir_seen) |=> $stable(fetch_addr_o));
endmodule

bind pipe5_ctrl pipe5_ctrl_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .of_busy_i    (of_busy_i),
  .br_resolve_i (br_resolve_i),
  .br_taken_i   (br_taken_i),
  .br_target_i  (br_target_i),
  .fetch_addr_o (fetch_addr_o),
  .kill_o       (kill_o),
  .stage_vld_o  (stage_vld_o),
  .retire_o     (retire_o)
);

// File: tb/sim_pipe5_ctrl.sv
`timescale 1ns/1ps
module sim_pipe5_ctrl;
  localparam int TW = 8;
  localparam int AW = 32;
  localparam int SLOT = 4;
  localparam logic [AW-1:0] RVEC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reset_vec = RVEC;
  logic in_valid = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic in_ready;
  logic of_busy = 1'b0, br_res = 1'b0, br_tk = 1'b0;
  logic [AW-1:0] br_tgt = '0;
  logic [AW-1:0] faddr;
  logic [4:0] adv, vld;
  logic [2:0] kill;
  logic retire;
  logic [TW-1:0] rtag;

  always #4 clk = ~clk;

  pipe5_ctrl #(.TAG_W(TW), .ADDR_W(AW), .SLOT_BYTES(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .reset_vec_i(reset_vec),
    .in_valid_i(in_valid), .in_tag_i(in_tag), .in_ready_o(in_ready),
    .of_busy_i(of_busy), .br_resolve_i(br_res), .br_taken_i(br_tk),
    .br_target_i(br_tgt), .fetch_addr_o(faddr), .stage_adv_o(adv),
    .kill_o(kill), .stage_vld_o(vld), .retire_o(retire), .retire_tag_o(rtag)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [4:0] mv;
  logic [TW-1:0] mt [5];
  logic [AW-1:0] mpc;
  int retired;

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_adv(input logic stl);
    return stl ? 5'b11000 : 5'b11111;
  endfunction

  // drive one cycle at negedge, check outputs, advance model across the edge
  task automatic step(input logic iv, input logic [TW-1:0] it, input logic ob,
                      input logic br, input logic bt, input logic [AW-1:0] tg);
    logic red, stl, rdy;
    logic [4:0] nv;
    logic [TW-1:0] nt [5];
    in_valid = iv; in_tag = it; of_busy = ob; br_res = br; br_tk = bt; br_tgt = tg;
    #1;
    red = br & bt & mv[3];
    stl = ob & mv[2] & ~red;
    rdy = ~stl & ~red;
    chk(in_ready == rdy, "R3 in_ready", AW'(in_ready), AW'(rdy));
    chk(adv == exp_adv(stl), "R4 stage_adv", AW'(adv), AW'(exp_adv(stl)));
    chk(kill == (red ? mv[2:0] : 3'b000), "R6 kill", AW'(kill), AW'(red ? mv[2:0] : 3'b000));
    chk(vld == mv, "R1 stage_vld", AW'(vld), AW'(mv));
    chk(faddr == mpc, "R8 fetch_addr", faddr, mpc);
    chk(retire == mv[4], "R1 retire", AW'(retire), AW'(mv[4]));
    if (mv[4]) chk(rtag == mt[4], "R1 retire_tag", AW'(rtag), AW'(mt[4]));
    if (retire) retired++;
    for (int i = 0; i < 5; i++) begin nv[i] = mv[i]; nt[i] = mt[i]; end
    nv[4] = mv[3]; nt[4] = mt[3];
    nv[3] = mv[2] & ~stl & ~red; nt[3] = mt[2];
    if (red) nv[2:0] = 3'b000;
    else if (!stl) begin
      nv[2] = mv[1]; nt[2] = mt[1];
      nv[1] = mv[0]; nt[1] = mt[0];
      nv[0] = iv; if (iv) nt[0] = it;
    end
    if (red) mpc = tg;
    else if (iv && rdy) mpc = mpc + AW'(SLOT);
    @(posedge clk);
    mv = nv;
    for (int i = 0; i < 5; i++) mt[i] = nt[i];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    int seed;
    logic [TW-1:0] tcount;
    seed = 32'd4711;
    void'($urandom(seed));
    mv = '0; mpc = RVEC; tcount = 8'h10;
    for (int i = 0; i < 5; i++) mt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(vld == 5'b0, "R9 valid after reset", AW'(vld), 0);
    chk(faddr == RVEC, "R9 reset vector", faddr, RVEC);

    // R1/R2 steady stream
    retired = 0;
    for (int i = 0; i < 5; i++) begin step(1'b1, tcount, 1'b0, 1'b0, 1'b0, '0); tcount++; end
    retired = 0;
    for (int i = 0; i < 10; i++) begin step(1'b1, tcount, 1'b0, 1'b0, 1'b0, '0); tcount++; end
    chk(retired == 10, "R2 one retire per cycle", AW'(retired), 10);

    // R4 long busy while stream offered
    for (int i = 0; i < 6; i++) step(1'b1, tcount, 1'b1, 1'b0, 1'b0, '0);
    chk(vld[3] == 1'b0 && vld[2:0] == 3'b111, "R4 upstream held, execute bubbled", AW'(vld), 5'b00111);
    step(1'b1, tcount, 1'b0, 1'b0, 1'b0, '0); tcount++;

    // R5 not-taken branch is a no-op
    step(1'b1, tcount, 1'b0, 1'b1, 1'b0, 32'hdead_0000); tcount++;
    chk(vld[2:0] == 3'b111 && faddr != 32'hdead_0000, "R5 not-taken no flush", AW'(vld), 5'b11111);

    // R7 taken redirect and busy together
    step(1'b1, tcount, 1'b1, 1'b1, 1'b1, 32'h0000_4000);
    chk(vld[2:0] == 3'b000 && vld[4] == 1'b1, "R7 redirect beats stall", AW'(vld), 5'b10000);
    chk(faddr == 32'h0000_4000, "R7 redirect target", faddr, 32'h0000_4000);

    // R11 busy with empty operand fetch; R10 resolve with empty execute
    step(1'b1, tcount, 1'b1, 1'b1, 1'b1, 32'h0000_8000); tcount++;
    chk(in_ready == 1'b1 || vld[0] == 1'b1, "R11 busy ignored when empty", AW'(vld), 5'b00001);
    chk(faddr == 32'h0000_4004, "R10 resolve ignored when execute empty", faddr, 32'h0000_4004);
    idle(6);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic iv, ob, br, bt;
      iv = ($urandom % 4) != 0;
      ob = ($urandom % 3) == 0;
      br = ($urandom % 4) == 0;
      bt = $urandom % 2;
      step(iv, tcount, ob, br, bt, {$urandom} & 32'hffff_fffc);
      tcount++;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule